// File: doc/BRIEF.md
# Joinable Two-Channel Pulse-Width Modulator

This block holds two pulse-width modulator channels, each 8 bits wide. They can run as two independent outputs, or a single control bit can merge them into one 16-bit modulator. Every channel counts ticks from one of two shared prescaled tick sources, A and B. Each source divides the bus clock by a power of two that a 3-bit field selects. All waveforms are left-aligned: the output rises when the counter returns to zero and falls when the counter matches the duty value.

A small synchronous register bus configures the block. Software must follow a fixed order to start a channel:

1. Disable the channel.
2. Set the join bit, the prescalers, the clock selects, the periods and the duties.
3. Write the channel's counter.
4. Set the enable bit.

When the channels are merged, the even channel holds the upper byte of every 16-bit quantity and the odd channel holds the lower byte. The merged waveform leaves on the even pin. The odd channel's clock select chooses the tick source.

Top module: `pwm_pair_top`

## Requirements
- R1: After reset, every register reads 0 and both outputs are low.
- R2: Address 0 is the control register. Bit 6 joins the channels, bits 5..3 hold the source A prescale exponent and bits 2..0 hold the source B exponent. Bit 7 always reads 0. The register can be written and read at any time.
- R3: Source A ticks once every 2^a bus cycles, where a is its exponent field, so the divider runs from 1 to 128. Source B follows the same rule with its own field.
- R4: Address 2 bit i selects the tick source of channel i: 0 selects A and 1 selects B.
- R5: Channel i uses period register 5+i and duty register 7+i, and its counter runs 0..P-1 once per tick. The output is high while the counter is below D and low otherwise. If D >= P the output stays high. If D = 0 or P = 0 the output stays low.
- R6: Address 1 bit i enables channel i, and the upper bits read 0. A disabled channel drives its output low and its counter holds its value.
- R7: A write of any value to counter address 3+i sets that counter to 0 and loads the active period and duty at once. A change to the period or duty written at any other time takes effect only when the counter wraps.
- R8: When joined, the period is {reg5,reg6}, the duty is {reg7,reg8} and the counter reads as {addr3,addr4}. The 16-bit waveform appears on pwm_out[0], and enable bit 0 runs it.
- R9: When joined, select bit 1 chooses the tick source and select bit 0 has no effect.
- R10: When joined, pwm_out[1] stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 4 | Register address for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | Modulator outputs, bit i for channel i |

## Verification
The assertions check the following on every cycle:
- The odd pin stays quiet while the channels are joined.
- A disabled channel drives its pin low.
- A counter write clears the counter on the next cycle.
- A stopped channel's counter holds its value.

Other behaviours can only be shown by the bench's scenarios. These are the prescaler rates, the choice between sources, the duty and period shapes, the deferred reload at wrap and the byte order of the merged counter. The bench counts high cycles and rising edges over windows that are whole multiples of the expected period. A wrong divider or a wrong source therefore shows up as a wrong edge count, even when the duty ratio happens to match.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_EN    = 4'd1;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT0  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CNT1  = 4'd4;
    localparam logic [ADDR_W-1:0] A_PER0  = 4'd5;
    localparam logic [ADDR_W-1:0] A_PER1  = 4'd6;
    localparam logic [ADDR_W-1:0] A_DUTY0 = 4'd7;
    localparam logic [ADDR_W-1:0] A_DUTY1 = 4'd8;
endpackage

// File: rtl/pwm_pair_presc.sv
module pwm_pair_presc #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps_a,
    input  logic [PS_W-1:0] ps_b,
    output logic            tick_a,
    output logic            tick_b
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask_a, mask_b;

    always_comb begin
        div_d  = div_q + DIV_W'(1);
        mask_a = ~({DIV_W{1'b1}} << ps_a);
        mask_b = ~({DIV_W{1'b1}} << ps_b);
        tick_a = (div_q & mask_a) == mask_a;
        tick_b = (div_q & mask_b) == mask_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/pwm_pair_unit.sv
module pwm_pair_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] per_in,
    input  logic [W-1:0] duty_in,
    output logic [W-1:0] cnt_o,
    output logic         pwm_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] per;
        logic [W-1:0] duty;
    } unit_t;

    unit_t s_d, s_q;
    logic  wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.per == '0) || (s_q.cnt >= s_q.per - W'(1));
        if (restart) begin
            s_d.cnt  = '0;
            s_d.per  = per_in;
            s_d.duty = duty_in;
        end else if (run && tick) begin
            if (wrap) begin
                s_d.cnt  = '0;
                s_d.per  = per_in;
                s_d.duty = duty_in;
            end else begin
                s_d.cnt = s_q.cnt + W'(1);
            end
        end
        cnt_o = s_q.cnt;
        pwm_o = run && (s_q.per != '0) && (s_q.cnt < s_q.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PS_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    output logic [CNT_W-1:0]      bus_rdata,
    input  logic [1:0][CNT_W-1:0] cnt_rd,
    output logic                  cat_on,
    output logic [PS_W-1:0]       ps_a,
    output logic [PS_W-1:0]       ps_b,
    output logic [1:0]            en,
    output logic [1:0]            sel,
    output logic [1:0][CNT_W-1:0] per,
    output logic [1:0][CNT_W-1:0] duty,
    output logic [1:0]            cnt_wr
);
    localparam int CTRL_W = 2 * PS_W + 1;

    typedef struct packed {
        logic [CTRL_W-1:0]       ctrl;
        logic [1:0]              en;
        logic [1:0]              sel;
        logic [1:0][CNT_W-1:0]   per;
        logic [1:0][CNT_W-1:0]   duty;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  r_d.ctrl    = bus_wdata[CTRL_W-1:0];
                A_EN:    r_d.en      = bus_wdata[1:0];
                A_SEL:   r_d.sel     = bus_wdata[1:0];
                A_PER0:  r_d.per[0]  = bus_wdata;
                A_PER1:  r_d.per[1]  = bus_wdata;
                A_DUTY0: r_d.duty[0] = bus_wdata;
                A_DUTY1: r_d.duty[1] = bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = CNT_W'(r_q.ctrl);
            A_EN:    bus_rdata = CNT_W'(r_q.en);
            A_SEL:   bus_rdata = CNT_W'(r_q.sel);
            A_CNT0:  bus_rdata = cnt_rd[0];
            A_CNT1:  bus_rdata = cnt_rd[1];
            A_PER0:  bus_rdata = r_q.per[0];
            A_PER1:  bus_rdata = r_q.per[1];
            A_DUTY0: bus_rdata = r_q.duty[0];
            A_DUTY1: bus_rdata = r_q.duty[1];
            default: bus_rdata = '0;
        endcase
    end

    always_comb begin
        cat_on    = r_q.ctrl[CTRL_W-1];
        ps_a      = r_q.ctrl[2*PS_W-1:PS_W];
        ps_b      = r_q.ctrl[PS_W-1:0];
        en        = r_q.en;
        sel       = r_q.sel;
        per       = r_q.per;
        duty      = r_q.duty;
        cnt_wr[0] = bus_wr && (bus_addr == A_CNT0);
        cnt_wr[1] = bus_wr && (bus_addr == A_CNT1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top #(
    parameter int CNT_W = 8,
    parameter int PS_W  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wr,
    input  logic [pwm_pair_pkg::ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]                bus_wdata,
    output logic [CNT_W-1:0]                bus_rdata,
    output logic [1:0]                      pwm_out
);
    localparam int JW = 2 * CNT_W;

    logic                  cat_on;
    logic [PS_W-1:0]       ps_a, ps_b;
    logic [1:0]            en, sel, cnt_wr;
    logic [1:0][CNT_W-1:0] per, duty, cnt_rd, s_cnt;
    logic [1:0]            s_pwm, tick_sel;
    logic                  tick_a, tick_b, j_pwm;
    logic [JW-1:0]         j_cnt;

    pwm_pair_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_rd(cnt_rd),
        .cat_on(cat_on), .ps_a(ps_a), .ps_b(ps_b), .en(en), .sel(sel),
        .per(per), .duty(duty), .cnt_wr(cnt_wr)
    );

    pwm_pair_presc #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .ps_a(ps_a), .ps_b(ps_b),
        .tick_a(tick_a), .tick_b(tick_b)
    );

    for (genvar i = 0; i < 2; i++) begin : g_ch
        assign tick_sel[i] = sel[i] ? tick_b : tick_a;

        pwm_pair_unit #(.W(CNT_W)) u_unit (
            .clk(clk), .rst_n(rst_n), .restart(cnt_wr[i]),
            .run(!cat_on && en[i]), .tick(tick_sel[i]),
            .per_in(per[i]), .duty_in(duty[i]),
            .cnt_o(s_cnt[i]), .pwm_o(s_pwm[i])
        );
    end

    // Joined counter: even byte high, odd byte low, odd channel's tick source.
    pwm_pair_unit #(.W(JW)) u_join (
        .clk(clk), .rst_n(rst_n), .restart(|cnt_wr),
        .run(cat_on && en[0]), .tick(tick_sel[1]),
        .per_in({per[0], per[1]}), .duty_in({duty[0], duty[1]}),
        .cnt_o(j_cnt), .pwm_o(j_pwm)
    );

    always_comb begin
        cnt_rd[0]  = cat_on ? j_cnt[JW-1:CNT_W] : s_cnt[0];
        cnt_rd[1]  = cat_on ? j_cnt[CNT_W-1:0]  : s_cnt[1];
        pwm_out[0] = cat_on ? j_pwm : s_pwm[0];
        pwm_out[1] = !cat_on && s_pwm[1];
    end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [1:0]            pwm_out,
    input logic                  cat_on,
    input logic [1:0]            en,
    input logic [1:0][CNT_W-1:0] cnt_rd
);
    // R10
    odd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cat_on |-> !pwm_out[1]);

    // R6
    even_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[0] |-> !pwm_out[0]);

    // R6
    odd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[1] |-> !pwm_out[1]);

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNT0) |=> (cnt_rd[0] == '0));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cat_on && !en[0] && !(bus_wr && (bus_addr == A_CNT0 || bus_addr == A_CTRL)))
        |=> $stable(cnt_rd[0]));
endmodule

bind pwm_pair_top pwm_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .pwm_out(pwm_out), .cat_on(cat_on), .en(en), .cnt_rd(cnt_rd)
);

// File: tb/pwm_pair_top_bench.sv
module pwm_pair_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] pwm_out;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pwm_pair_top u_pwm_pair_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // {join, chan, sel0, sel1, psA[2:0], psB[2:0], period[15:0], duty[15:0]}
    localparam logic [41:0] VEC [10] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'd5,     16'd2},
        {1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 3'd2, 16'd6,     16'd3},
        {1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd3, 16'd4,     16'd4},
        {1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 3'd0, 16'd7,     16'd0},
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'd260,   16'd65},
        {1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 16'd300,   16'd100},
        {1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd2, 16'd258,   16'd259},
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 3'd0, 16'd3,     16'd1},
        {1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 16'h0200,  16'd1},
        {1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 16'd0,     16'd5}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int ch, input int settle, input int win,
                           output int hi, output int rises, output int other_hi);
        logic prev;
        hi = 0; rises = 0; other_hi = 0;
        for (int c = 0; c < settle; c++) @(negedge clk);
        prev = pwm_out[ch];
        for (int c = 0; c < win; c++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
            if (pwm_out[ch] && !prev) rises++;
            if (pwm_out[1-ch]) other_hi++;
            prev = pwm_out[ch];
        end
    endtask

    task automatic run_vec(input logic [41:0] v);
        logic       jn, ch, s0, s1, eff;
        logic [2:0] pa, pb;
        int         p, d, k, dv, win, exp_hi, exp_rise, hi, rises, oth;
        logic [7:0] r;
        jn = v[41]; ch = v[40]; s0 = v[39]; s1 = v[38];
        pa = v[37:35]; pb = v[34:32]; p = int'(v[31:16]); d = int'(v[15:0]);
        wr(4'd1, 8'h00);
        wr(4'd0, {1'b0, jn, pa, pb});
        wr(4'd2, {6'd0, s1, s0});
        if (jn) begin
            wr(4'd5, v[31:24]); wr(4'd6, v[23:16]);
            wr(4'd7, v[15:8]);  wr(4'd8, v[7:0]);
            wr(4'd4, 8'h00);
        end else begin
            wr(4'd5 + 4'(ch), v[23:16]);
            wr(4'd7 + 4'(ch), v[7:0]);
            wr(4'd3 + 4'(ch), 8'h00);
        end
        rd(4'd3 + 4'(ch), r);
        check("R7 counter cleared by write", int'(r), 0);
        wr(4'd1, jn ? 8'h01 : (ch ? 8'h02 : 8'h01));
        // R9: when joined the odd select decides; R4 otherwise.
        eff = jn ? s1 : (ch ? s1 : s0);
        k   = eff ? int'(pb) : int'(pa);
        dv  = 1 << k;
        win = (p == 0) ? 32 : 2 * p * dv;
        exp_hi   = (p == 0) ? 0 : 2 * ((d < p) ? d : p) * dv;
        exp_rise = (p > 0 && d > 0 && d < p) ? 2 : 0;
        measure(jn ? 0 : int'(ch), win, win, hi, rises, oth);
        if (jn) begin
            check("R8 joined high cycles", hi, exp_hi);
            check("R9 joined periods seen", rises, exp_rise);
            check("R10 odd pin quiet while joined", oth, 0);
        end else begin
            check("R5 high cycles", hi, exp_hi);
            check("R3 periods seen", rises, exp_rise);
            check("R6 disabled neighbour low", oth, 0);
        end
    endtask

    initial begin
        logic [7:0] r, a, b;
        int         hi, rises, oth;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 9; i++) begin
            rd(4'(i), r);
            check("R1 register reset value", int'(r), 0);
        end
        check("R1 outputs low after reset", int'(pwm_out), 0);

        // R2: control register layout and read-back
        wr(4'd0, 8'hFF);
        rd(4'd0, r);
        check("R2 control read-back", int'(r), 8'h7F);
        wr(4'd0, 8'h00);
        wr(4'd1, 8'hFF);
        rd(4'd1, r);
        check("R6 enable field width", int'(r), 3);
        wr(4'd1, 8'h00);

        for (int i = 0; i < 10; i++) run_vec(VEC[i]);

        // R6: stopping a channel holds its counter and drives it low
        wr(4'd1, 8'h00); wr(4'd0, 8'h00); wr(4'd2, 8'h00);
        wr(4'd5, 8'd200); wr(4'd7, 8'd100); wr(4'd3, 8'h00);
        wr(4'd1, 8'h01);
        repeat (30) @(negedge clk);
        wr(4'd1, 8'h00);
        rd(4'd3, a);
        repeat (20) @(negedge clk);
        rd(4'd3, b);
        check("R6 counter held while disabled", int'(b), int'(a));
        check("R6 stopped output low", int'(pwm_out[0]), 0);

        // R7: period change without counter write takes effect at wrap
        wr(4'd6, 8'd10); wr(4'd8, 8'd5); wr(4'd4, 8'h00);
        wr(4'd1, 8'h02);
        repeat (3) @(negedge clk);
        wr(4'd6, 8'd4); wr(4'd8, 8'd1);
        measure(1, 24, 8, hi, rises, oth);
        check("R7 new duty after wrap", hi, 2);
        check("R7 new period after wrap", rises, 2);

        // R8: even counter byte holds the high-order part
        wr(4'd1, 8'h00); wr(4'd0, 8'h40); wr(4'd2, 8'h00);
        wr(4'd5, 8'd3); wr(4'd6, 8'd0); wr(4'd7, 8'd1); wr(4'd8, 8'd0);
        wr(4'd3, 8'h00);
        wr(4'd1, 8'h01);
        repeat (400) @(negedge clk);
        wr(4'd1, 8'h00);
        rd(4'd3, r);
        check("R8 counter high byte on even address", int'(r), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule